// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Skip Flush

This block divides the core clock into instruction cycles of four phases and controls the fetch/execute overlap of a small pipelined processor. In every cycle it executes the word held in its instruction register and fetches the next word. On the edge that closes the last phase it latches the fetched word into the instruction register.

An external decoder classifies the instruction currently in the register. The datapath supplies a bit-test result and a zero-result flag. The sequencer samples these once per cycle, at the close of the execute phase. From them it decides whether the current instruction takes one cycle or two.

A two-cycle outcome occurs when the instruction writes the program counter or when a skip condition is true. Program-counter writes include jumps, calls, returns and an addition into the counter's low byte. In that case the sequencer raises `flush` during the last phase. The word that was just fetched is then discarded, and a no-operation word is loaded in its place, so the following cycle runs as a forced no-operation. With a 4 MHz core clock an ordinary instruction takes 1 µs, and a flushed one takes 2 µs.

Top module: `icyc_seq`

## Requirements
- R1: While `rst_n` is low, and until the second rising edge after its release, the outputs are `phase`=0001, `fetch_en`=0, `flush`=0, `ir_word`=NOP_WORD (default 0) and `nop_cycle`=1. The first cycle after reset is therefore a no-operation.
- R2: `phase` is one-hot, with bit 0 for Q1, bit 1 for Q2, bit 2 for Q3 and bit 3 for Q4. It advances by one position on each rising clock edge and wraps from Q4 to Q1.
- R3: `fetch_en` is high exactly during Q4. `ir_word` changes only on the edge that closes Q4, and `fetch_word` is sampled only on that edge.
- R4: Class codes 0 (plain), 6 and 7 never raise `flush`. After such an instruction, the next cycle has `ir_word` equal to the fetched word and `nop_cycle`=0.
- R5: Class 1 (program-counter write: jump, call or return) raises `flush` in Q4. The next cycle then has `ir_word`=NOP_WORD and `nop_cycle`=1.
- R6: Class 2 (bit test, skip if clear) raises `flush` in Q4 exactly when `test_bit` is 0.
- R7: Class 3 (bit test, skip if set) raises `flush` in Q4 exactly when `test_bit` is 1.
- R8: Class 4 (increment or decrement, skip if the 8-bit result is zero) raises `flush` in Q4 exactly when `zero_res` is 1.
- R9: Class 5 (addition into the program-counter low byte) counts as a program-counter write and behaves as in R5.
- R10: During a cycle with `nop_cycle`=1, the class and test inputs are ignored. `flush` stays low, and the next fetched word is loaded, so a forced no-operation lasts exactly one cycle.
- R11: `ins_class`, `test_bit` and `zero_res` are sampled only on the edge that closes Q3. Their values in Q1, Q2 and Q4 have no effect on `flush`.
- R12: `flush` is never high outside Q4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (one phase per period) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_word | input | IW | Word returned by program memory, valid in Q4 |
| ins_class | input | 3 | Class of the executing instruction, valid in Q3 |
| test_bit | input | 1 | Tested bit of the operand, valid in Q3 |
| zero_res | input | 1 | Zero flag of the 8-bit result, valid in Q3 |
| phase | output | NUM_PH | One-hot phase strobes Q1..Q4 |
| fetch_en | output | 1 | High in Q4, when the next word is latched |
| flush | output | 1 | Discard the fetched word and load a no-operation |
| ir_word | output | IW | Instruction register |
| nop_cycle | output | 1 | The current cycle executes a forced no-operation |

## Verification
A corrupted phase ring shows up at the ports within one clock, as a missing or doubled strobe. A stale skip decision shows up in the Q4 of the same cycle as a wrong `flush`. In the following Q1 it also appears as a wrong `ir_word`/`nop_cycle` pair. A mishandled forced no-operation would let a flush run back to back; this is visible one cycle later, because a second consecutive NOP would appear. The stimulus puts random values on the class and test inputs in every phase except Q3, so sampling in the wrong phase changes `flush` within the same cycle.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [2:0] {
    CL_PLAIN     = 3'd0,
    CL_PCWRITE   = 3'd1,
    CL_SKIP_CLR  = 3'd2,
    CL_SKIP_SET  = 3'd3,
    CL_SKIP_ZERO = 3'd4,
    CL_PCL_ADD   = 3'd5,
    CL_SPARE6    = 3'd6,
    CL_SPARE7    = 3'd7
  } ins_class_e;

  function automatic logic skip_wanted(input ins_class_e c, input logic tbit,
                                       input logic zres);
    logic r;
    case (c)
      CL_PCWRITE,
      CL_PCL_ADD:   r = 1'b1;
      CL_SKIP_CLR:  r = ~tbit;
      CL_SKIP_SET:  r = tbit;
      CL_SKIP_ZERO: r = zres;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/icyc_phase_ring.sv
module icyc_phase_ring #(
  parameter int NUM_PH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NUM_PH-1:0] ph
);
  localparam logic [NUM_PH-1:0] PH_FIRST = NUM_PH'(1);

  logic [NUM_PH-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = {ph_q[NUM_PH-2:0], ph_q[NUM_PH-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FIRST;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;

  // R2: exactly one phase strobe is active at any time
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph_q) == 1);

  // R2: each phase hands over to its successor on the next edge
  for (genvar i = 0; i < NUM_PH; i++) begin : g_rot
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q[i] |=> ph_q[(i + 1) % NUM_PH]);
  end

endmodule

// File: rtl/icyc_skip_judge.sv
module icyc_skip_judge
  import icyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph_exec,
  input  logic       ph_wb,
  input  logic       nop_cycle,
  input  logic [2:0] ins_class,
  input  logic       test_bit,
  input  logic       zero_res,
  output logic       flush
);
  logic skip_q, skip_d, skip_en;

  always_comb begin
    skip_en = ph_exec | ph_wb;
    skip_d  = 1'b0;
    if (ph_exec)
      skip_d = ~nop_cycle & skip_wanted(ins_class_e'(ins_class), test_bit, zero_res);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       skip_q <= 1'b0;
    else if (skip_en) skip_q <= skip_d;
  end

  assign flush = skip_q & ph_wb;

  // R12: a pending decision exists only between the execute and write-back phases
  a_r12_flush_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(ph_exec));

  // R10: a forced no-operation cycle never produces a skip decision
  a_r10_nop_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_exec && nop_cycle) |=> !skip_q);

endmodule

// File: rtl/icyc_ireg.sv
module icyc_ireg #(
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          flush,
  input  logic [IW-1:0] fetch_word,
  output logic [IW-1:0] ir_word,
  output logic          nop_cycle
);
  logic [IW-1:0] ir_q, ir_d;
  logic          nop_q, nop_d;

  always_comb begin
    ir_d  = flush ? NOP_WORD : fetch_word;
    nop_d = flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= NOP_WORD;
      nop_q <= 1'b1;
    end else if (load) begin
      ir_q  <= ir_d;
      nop_q <= nop_d;
    end
  end

  assign ir_word   = ir_q;
  assign nop_cycle = nop_q;

  // R3: the instruction register holds its word outside the load phase
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ir_q) && $stable(nop_q));

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int            NUM_PH   = 4,
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     fetch_word,
  input  logic [2:0]        ins_class,
  input  logic              test_bit,
  input  logic              zero_res,
  output logic [NUM_PH-1:0] phase,
  output logic              fetch_en,
  output logic              flush,
  output logic [IW-1:0]     ir_word,
  output logic              nop_cycle
);
  localparam int SYNC_N  = 2;
  localparam int PH_EXEC = NUM_PH - 2;
  localparam int PH_WB   = NUM_PH - 1;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  logic [NUM_PH-1:0] ph;

  icyc_phase_ring #(.NUM_PH(NUM_PH)) u_ring (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ph    (ph)
  );

  icyc_skip_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ph_exec   (ph[PH_EXEC]),
    .ph_wb     (ph[PH_WB]),
    .nop_cycle (nop_cycle),
    .ins_class (ins_class),
    .test_bit  (test_bit),
    .zero_res  (zero_res),
    .flush     (flush)
  );

  icyc_ireg #(.IW(IW), .NOP_WORD(NOP_WORD)) u_ireg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (ph[PH_WB]),
    .flush      (flush),
    .fetch_word (fetch_word),
    .ir_word    (ir_word),
    .nop_cycle  (nop_cycle)
  );

  assign phase    = ph;
  assign fetch_en = ph[PH_WB];

  // R5 / R9: a flush yields exactly a NOP word in the next cycle
  a_r5_flush_gives_nop: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |=> nop_cycle && (ir_word == NOP_WORD));

  // R4: an unflushed fetch leaves a live instruction in the register
  a_r4_fetch_live: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_en && !flush) |=> !nop_cycle);

  // R10: a forced no-operation is never itself flushed
  a_r10_single_nop: assert property (@(posedge clk) disable iff (!rst_int_n)
    nop_cycle |-> !flush);

endmodule

// File: tb/sim_icyc_seq.sv
module sim_icyc_seq;
  localparam int            NUM_PH = 4;
  localparam int            IW     = 14;
  localparam logic [IW-1:0] NOPW   = '0;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [IW-1:0]     fetch_word;
  logic [2:0]        ins_class;
  logic              test_bit, zero_res;
  logic [NUM_PH-1:0] phase;
  logic              fetch_en, flush, nop_cycle;
  logic [IW-1:0]     ir_word;

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] exp_ir;
  logic          exp_nop;

  always #2 clk = ~clk;

  icyc_seq #(.NUM_PH(NUM_PH), .IW(IW), .NOP_WORD(NOPW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .ins_class(ins_class),
    .test_bit(test_bit), .zero_res(zero_res), .phase(phase), .fetch_en(fetch_en),
    .flush(flush), .ir_word(ir_word), .nop_cycle(nop_cycle)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_take(input logic [2:0] c, input logic tb,
                                      input logic zr, input logic nop);
    if (nop) return 1'b0;
    case (c)
      3'd1, 3'd5: return 1'b1;
      3'd2:       return ~tb;
      3'd3:       return tb;
      3'd4:       return zr;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic nop);
    if (nop) return "R10 flush in nop cycle";
    case (c)
      3'd1:    return "R5 pc write flush";
      3'd2:    return "R6 skip-if-clear flush";
      3'd3:    return "R7 skip-if-set flush";
      3'd4:    return "R8 skip-if-zero flush";
      3'd5:    return "R9 pcl add flush";
      default: return "R4 plain no flush";
    endcase
  endfunction

  task automatic junk();
    ins_class  = 3'($urandom);
    test_bit   = 1'($urandom);
    zero_res   = 1'($urandom);
    fetch_word = IW'($urandom);
  endtask

  // Entered just after the negedge inside Q1; leaves at the negedge inside the next Q1.
  task automatic run_cycle(input logic [2:0] c, input logic tb, input logic zr,
                           input logic [IW-1:0] w);
    logic take;
    chk(phase == 4'b0001, "R2 phase Q1", 32'(phase), 32'h1);
    chk(!fetch_en, "R3 fetch_en low in Q1", 32'(fetch_en), 0);
    chk(ir_word == exp_ir, exp_nop ? "R5 ir holds NOP" : "R4 ir holds fetched word",
        32'(ir_word), 32'(exp_ir));
    chk(nop_cycle == exp_nop, "R4 nop_cycle", 32'(nop_cycle), 32'(exp_nop));
    chk(!flush, "R12 flush low in Q1", 32'(flush), 0);
    junk();
    @(negedge clk);
    chk(phase == 4'b0010, "R2 phase Q2", 32'(phase), 32'h2);
    chk(!flush, "R12 flush low in Q2", 32'(flush), 0);
    junk();
    @(negedge clk);
    chk(phase == 4'b0100, "R2 phase Q3", 32'(phase), 32'h4);
    chk(ir_word == exp_ir, "R3 ir stable before Q4", 32'(ir_word), 32'(exp_ir));
    ins_class = c; test_bit = tb; zero_res = zr;
    fetch_word = IW'($urandom);
    @(negedge clk);
    take = model_take(c, tb, zr, exp_nop);
    chk(phase == 4'b1000, "R2 phase Q4", 32'(phase), 32'h8);
    chk(fetch_en, "R3 fetch_en in Q4", 32'(fetch_en), 1);
    chk(flush == take, tag_of(c, exp_nop), 32'(flush), 32'(take));
    junk();
    fetch_word = w;
    exp_ir  = take ? NOPW : w;
    exp_nop = take;
    @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    junk();
    repeat (3) @(negedge clk);
    chk(phase == 4'b0001, "R1 reset phase", 32'(phase), 1);
    chk(ir_word == NOPW, "R1 reset ir", 32'(ir_word), 32'(NOPW));
    chk(nop_cycle, "R1 reset nop_cycle", 32'(nop_cycle), 1);
    chk(!flush && !fetch_en, "R1 reset flush/fetch_en", {30'd0, flush, fetch_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(phase == 4'b0001, "R1 phase held during sync", 32'(phase), 1);
    exp_ir = NOPW; exp_nop = 1'b1;
    // first cycle is a NOP: a jump class must be ignored (R10)
    run_cycle(3'd1, 1'b0, 1'b0, 14'h0123);
    run_cycle(3'd0, 1'b0, 1'b1, 14'h0456);   // R4
    run_cycle(3'd1, 1'b0, 1'b0, 14'h0789);   // R5
    run_cycle(3'd5, 1'b0, 1'b0, 14'h0ABC);   // R10: nop after flush ignores class 5
    run_cycle(3'd5, 1'b1, 1'b1, 14'h1111);   // R9
    run_cycle(3'd0, 1'b0, 1'b0, 14'h2222);
    run_cycle(3'd2, 1'b0, 1'b0, 14'h3333);   // R6 taken
    run_cycle(3'd2, 1'b1, 1'b0, 14'h0444);   // R10 nop
    run_cycle(3'd2, 1'b1, 1'b1, 14'h0555);   // R6 not taken
    run_cycle(3'd3, 1'b0, 1'b1, 14'h0666);   // R7 not taken
    run_cycle(3'd3, 1'b1, 1'b0, 14'h0777);   // R7 taken
    run_cycle(3'd0, 1'b0, 1'b0, 14'h0888);
    run_cycle(3'd4, 1'b1, 1'b0, 14'h0999);   // R8 not taken
    run_cycle(3'd4, 1'b0, 1'b1, 14'h0AAA);   // R8 taken
    run_cycle(3'd6, 1'b0, 1'b1, 14'h0BBB);
    run_cycle(3'd7, 1'b1, 1'b1, 14'h0CCC);   // R4 spare codes
    // R11: inputs outside Q3 are randomized inside run_cycle for every cycle
    for (int k = 0; k < 400; k++)
      run_cycle(3'($urandom), 1'($urandom), 1'($urandom), IW'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule